// File: doc/BRIEF.md
# Floating-Point Operand and Result Conditioner

This block sits at the edge of a single-precision floating-point datapath. On the way in, it decodes each operand of an operation into one of six categories and raises an invalid-operation flag when a signalling NaN is among the operands. When flush-to-zero is enabled, it replaces subnormal operands with positive zero. On the way out, it takes an unrounded result and a flag that marks the result as tiny. When flush-to-zero is enabled, it turns a tiny nonzero result into positive zero. It also handles NaN results: it either replaces them with one canonical NaN or turns them into quiet NaNs.

The arithmetic and the rounding are done elsewhere. The conditioner only looks at encodings. The operand side and the result side are independent. Each side has its own valid strobe, and each registers its outputs once, so every output appears one clock after its input. The two mode controls are sampled in the same cycle as the data they apply to.

Top module: `fp_operand_conditioner`

## Requirements
- R1: Each operand's category is a one-hot 6-bit vector. Bit 0 is zero, bit 1 is subnormal, bit 2 is normal, bit 3 is infinity, bit 4 is quiet NaN and bit 5 is signalling NaN. The encodings are:
  - zero: exponent 0 and fraction 0.
  - subnormal: exponent 0 and fraction nonzero.
  - normal: any other exponent below all-ones.
  - infinity: exponent all-ones and fraction 0.
  - quiet NaN: exponent all-ones and fraction bit 22 set.
  - signalling NaN: exponent all-ones, fraction bit 22 clear and fraction nonzero.
- R2: When flush-to-zero is off, every operand, subnormals included, is passed to the output unchanged.
- R3: When flush-to-zero is on, a subnormal operand of either sign is output as 0x00000000. Its category still reports subnormal. Operands of the other categories pass unchanged.
- R4: The invalid flag is high exactly when the operand strobe was high and at least one operand is a signalling NaN. Quiet NaNs never raise it.
- R5: When flush-to-zero is on and the tiny flag is set, a result that is not an encoded zero is output as 0x00000000, whatever its sign.
- R6: A result that is an encoded zero (0x00000000 or 0x80000000) is output unchanged even when flush-to-zero is on and the tiny flag is set.
- R7: When flush-to-zero is off, a result marked tiny passes unchanged.
- R8: When default-NaN mode is on, every NaN result, quiet or signalling, of either sign, is output as 0x7FC00000.
- R9: When default-NaN mode is off, a signalling NaN result is output with fraction bit 22 set and all other bits unchanged. A quiet NaN result passes unchanged.
- R10: All outputs and both output strobes change one clock after their inputs. After reset, every output is zero and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ftz_en | input | 1 | Flush-to-zero mode |
| dnan_en | input | 1 | Default-NaN mode |
| op_vld | input | 1 | Operand set valid |
| op_in | input | NUM_OPS x 32 | Raw operands, lane 0 in the low word |
| res_vld | input | 1 | Unrounded result valid |
| res_in | input | 32 | Unrounded result |
| res_tiny | input | 1 | Result lies in the subnormal range before rounding |
| op_vld_q | output | 1 | Conditioned operands valid |
| op_out | output | NUM_OPS x 32 | Conditioned operands |
| op_cls | output | NUM_OPS x 6 | One-hot category per operand |
| op_invalid | output | 1 | Signalling NaN seen among operands |
| res_vld_q | output | 1 | Conditioned result valid |
| res_out | output | 32 | Conditioned result |

## Verification
The assertions assume a consistent producer. The tiny flag is only raised together with a result whose exponent field is zero or would be zero before rounding. It is never raised with an infinity or NaN result. The mode controls are assumed to be steady in the cycle their data is presented. The bench therefore marks only zero-exponent results as tiny. It changes the mode bits only at the negative edge, in the same step that it presents the data they govern. This keeps every checked vector inside those assumptions.

// File: rtl/fpc_pkg.sv
// Package: shared category indices for the conditioner.
// Assumes a six-category one-hot scheme, with index order fixed by downstream decoders.
package fpc_pkg;
    localparam int CLS_W     = 6;
    localparam int CLS_ZERO  = 0;
    localparam int CLS_SUB   = 1;
    localparam int CLS_NORM  = 2;
    localparam int CLS_INF   = 3;
    localparam int CLS_QNAN  = 4;
    localparam int CLS_SNAN  = 5;
endpackage

// File: rtl/fpc_classify.sv
// Module: combinational decode of one IEEE-style encoding into a one-hot category.
// Assumes FRAC_W >= 2 so that the quiet bit and a payload bit both exist.
module fpc_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]              val,
    output logic [fpc_pkg::CLS_W-1:0] cls
);
    import fpc_pkg::*;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_zero, exp_ones, frac_zero, quiet_bit;

    // Split the fields and form the basic field tests.
    always_comb begin
        exp_f     = val[W-2 -: EXP_W];
        frac_f    = val[FRAC_W-1:0];
        exp_zero  = (exp_f == '0);
        exp_ones  = (exp_f == '1);
        frac_zero = (frac_f == '0);
        quiet_bit = frac_f[FRAC_W-1];
    end

    // Map the field tests onto exactly one category bit.
    always_comb begin
        cls            = '0;
        cls[CLS_ZERO]  = exp_zero & frac_zero;
        cls[CLS_SUB]   = exp_zero & ~frac_zero;
        cls[CLS_NORM]  = ~exp_zero & ~exp_ones;
        cls[CLS_INF]   = exp_ones & frac_zero;
        cls[CLS_QNAN]  = exp_ones & quiet_bit;
        cls[CLS_SNAN]  = exp_ones & ~quiet_bit & ~frac_zero;
    end
endmodule

// File: rtl/fpc_operand_lane.sv
// Module: conditions one operand: classifies it and flushes subnormals when asked.
// Assumes the caller registers the outputs; this lane is purely combinational.
module fpc_operand_lane #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]              raw,
    input  logic                      ftz,
    output logic [W-1:0]              cond,
    output logic [fpc_pkg::CLS_W-1:0] cls,
    output logic                      is_snan
);
    import fpc_pkg::*;

    fpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .val (raw),
        .cls (cls)
    );

    // Subnormal operands become positive zero in flush mode; all else passes.
    always_comb begin
        cond    = (ftz && cls[CLS_SUB]) ? '0 : raw;
        is_snan = cls[CLS_SNAN];
    end
endmodule

// File: rtl/fpc_result_path.sv
// Module: conditions an unrounded result: tiny flushing and NaN handling.
// Assumes tiny is only raised for finite results below the normal range.
module fpc_result_path #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] res,
    input  logic         tiny,
    input  logic         ftz,
    input  logic         dnan,
    output logic [W-1:0] cond
);
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic exp_ones, frac_zero, mag_zero, is_nan, do_flush;

    // Decode the result fields needed by the selection below.
    always_comb begin
        exp_ones  = (res[W-2 -: EXP_W] == '1);
        frac_zero = (res[FRAC_W-1:0] == '0);
        mag_zero  = (res[W-2:0] == '0);
        is_nan    = exp_ones & ~frac_zero;
        do_flush  = ftz & tiny & ~mag_zero;
    end

    // Select flushed zero, canonical NaN, quieted NaN or the result itself.
    always_comb begin
        if (do_flush) begin
            cond = '0;
        end else if (is_nan && dnan) begin
            cond = CANON_NAN;
        end else if (is_nan) begin
            cond = res;
            cond[FRAC_W-1] = 1'b1;
        end else begin
            cond = res;
        end
    end
endmodule

// File: rtl/fp_operand_conditioner.sv
// Module: top of the conditioner. It runs NUM_OPS operand lanes and one result
// path, and registers every output once.
// Assumes the mode bits are valid in the same cycle as the data they govern.
module fp_operand_conditioner #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int NUM_OPS = 2,
    localparam int W      = 1 + EXP_W + FRAC_W
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ftz_en,
    input  logic                                   dnan_en,
    input  logic                                   op_vld,
    input  logic [NUM_OPS-1:0][W-1:0]              op_in,
    input  logic                                   res_vld,
    input  logic [W-1:0]                           res_in,
    input  logic                                   res_tiny,
    output logic                                   op_vld_q,
    output logic [NUM_OPS-1:0][W-1:0]              op_out,
    output logic [NUM_OPS-1:0][fpc_pkg::CLS_W-1:0] op_cls,
    output logic                                   op_invalid,
    output logic                                   res_vld_q,
    output logic [W-1:0]                           res_out
);
    import fpc_pkg::*;

    logic [NUM_OPS-1:0][W-1:0]     lane_val;
    logic [NUM_OPS-1:0][CLS_W-1:0] lane_cls;
    logic [NUM_OPS-1:0]            lane_snan;
    logic [W-1:0]                  res_cond;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_lane
        fpc_operand_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
            .raw     (op_in[g]),
            .ftz     (ftz_en),
            .cond    (lane_val[g]),
            .cls     (lane_cls[g]),
            .is_snan (lane_snan[g])
        );
    end

    fpc_result_path #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_res (
        .res  (res_in),
        .tiny (res_tiny),
        .ftz  (ftz_en),
        .dnan (dnan_en),
        .cond (res_cond)
    );

    // Register the operand side; the invalid flag is qualified by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_vld_q   <= 1'b0;
            op_out     <= '0;
            op_cls     <= '0;
            op_invalid <= 1'b0;
        end else begin
            op_vld_q   <= op_vld;
            op_out     <= lane_val;
            op_cls     <= lane_cls;
            op_invalid <= op_vld & (|lane_snan);
        end
    end

    // Register the result side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld_q <= 1'b0;
            res_out   <= '0;
        end else begin
            res_vld_q <= res_vld;
            res_out   <= res_cond;
        end
    end
endmodule

// File: rtl/fpc_checker.sv
// Module: property checker for the conditioner, attached by bind below.
// Assumes the same parameter values as the instance it is bound to.
module fpc_checker #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int NUM_OPS = 2,
    localparam int W      = 1 + EXP_W + FRAC_W
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   ftz_en,
    input logic                                   dnan_en,
    input logic                                   op_vld,
    input logic [NUM_OPS-1:0][W-1:0]              op_in,
    input logic                                   res_vld,
    input logic [W-1:0]                           res_in,
    input logic                                   res_tiny,
    input logic                                   op_vld_q,
    input logic [NUM_OPS-1:0][W-1:0]              op_out,
    input logic [NUM_OPS-1:0][fpc_pkg::CLS_W-1:0] op_cls,
    input logic                                   op_invalid,
    input logic                                   res_vld_q,
    input logic [W-1:0]                           res_out
);
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [NUM_OPS-1:0] snan_seen;

    // Collect the registered signalling-NaN category bits of all lanes.
    always_comb begin
        for (int i = 0; i < NUM_OPS; i++) snan_seen[i] = op_cls[i][fpc_pkg::CLS_SNAN];
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_chk
        // R1
        cls_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            op_vld_q |-> $onehot(op_cls[g]));
        // R3
        no_sub_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_vld_q && $past(ftz_en)) |->
            !(op_out[g][W-2 -: EXP_W] == '0 && op_out[g][FRAC_W-1:0] != '0));
    end

    // R4
    invalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_invalid |-> (op_vld_q && (|snan_seen)));

    // R8
    dnan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_q && $past(dnan_en) && res_out[W-2 -: EXP_W] == '1 &&
         res_out[FRAC_W-1:0] != '0) |-> (res_out == CANON_NAN));

    // R9
    no_snan_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_q && res_out[W-2 -: EXP_W] == '1 && res_out[FRAC_W-1:0] != '0)
        |-> res_out[FRAC_W-1]);

    // R10
    res_vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> res_vld_q);
endmodule

bind fp_operand_conditioner fpc_checker #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .NUM_OPS(NUM_OPS)
) u_chk (.*);

// File: tb/fp_operand_conditioner_bench.sv
// Directed bench for the conditioner: one task per scenario.
module fp_operand_conditioner_bench;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ftz_en = 1'b0, dnan_en = 1'b0;
    logic              op_vld = 1'b0, res_vld = 1'b0, res_tiny = 1'b0;
    logic [1:0][31:0]  op_in = '0;
    logic [31:0]       res_in = '0;
    logic              op_vld_q, op_invalid, res_vld_q;
    logic [1:0][31:0]  op_out;
    logic [1:0][5:0]   op_cls;
    logic [31:0]       res_out;
    int                n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    fp_operand_conditioner u_fp_operand_conditioner (
        .clk(clk), .rst_n(rst_n), .ftz_en(ftz_en), .dnan_en(dnan_en),
        .op_vld(op_vld), .op_in(op_in), .res_vld(res_vld), .res_in(res_in),
        .res_tiny(res_tiny), .op_vld_q(op_vld_q), .op_out(op_out),
        .op_cls(op_cls), .op_invalid(op_invalid), .res_vld_q(res_vld_q),
        .res_out(res_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operand pair at the falling edge, then sample one clock later.
    task automatic op_step(input logic ftz, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        ftz_en = ftz; op_vld = 1'b1; op_in[0] = a; op_in[1] = b;
        @(negedge clk);
        op_vld = 1'b0;
    endtask

    task automatic res_step(input logic ftz, input logic dn, input logic tiny,
                            input logic [31:0] r);
        @(negedge clk);
        ftz_en = ftz; dnan_en = dn; res_vld = 1'b1; res_tiny = tiny; res_in = r;
        @(negedge clk);
        res_vld = 1'b0; res_tiny = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 op_vld_q", {31'd0, op_vld_q}, 32'd0);
        chk("R10 res_vld_q", {31'd0, res_vld_q}, 32'd0);
        chk("R10 res_out", res_out, 32'd0);
        chk("R10 op_out0", op_out[0], 32'd0);
        chk("R10 invalid", {31'd0, op_invalid}, 32'd0);
    endtask

    task automatic t_classify();
        op_step(1'b0, 32'h0000_0000, 32'h0000_0001);
        chk("R1 zero", {26'd0, op_cls[0]}, 32'h01);
        chk("R1 sub", {26'd0, op_cls[1]}, 32'h02);
        chk("R10 op_vld_q", {31'd0, op_vld_q}, 32'd1);
        op_step(1'b0, 32'hBF80_0000, 32'hFF80_0000);
        chk("R1 normal", {26'd0, op_cls[0]}, 32'h04);
        chk("R1 inf", {26'd0, op_cls[1]}, 32'h08);
        op_step(1'b0, 32'h7FC0_0000, 32'hFF80_0001);
        chk("R1 qnan", {26'd0, op_cls[0]}, 32'h10);
        chk("R1 snan", {26'd0, op_cls[1]}, 32'h20);
        op_step(1'b0, 32'h7F7F_FFFF, 32'h8000_0000);
        chk("R1 max normal", {26'd0, op_cls[0]}, 32'h04);
        chk("R1 neg zero", {26'd0, op_cls[1]}, 32'h01);
    endtask

    task automatic t_ftz_ops();
        op_step(1'b0, 32'h8040_0000, 32'h007F_FFFF);
        chk("R2 sub pass a", op_out[0], 32'h8040_0000);
        chk("R2 sub pass b", op_out[1], 32'h007F_FFFF);
        op_step(1'b1, 32'h8040_0000, 32'h0000_0001);
        chk("R3 neg sub flushed", op_out[0], 32'h0000_0000);
        chk("R3 pos sub flushed", op_out[1], 32'h0000_0000);
        chk("R3 class kept", {26'd0, op_cls[0]}, 32'h02);
        op_step(1'b1, 32'h0080_0000, 32'h8000_0000);
        chk("R3 min normal kept", op_out[0], 32'h0080_0000);
        chk("R3 neg zero kept", op_out[1], 32'h8000_0000);
    endtask

    task automatic t_invalid();
        op_step(1'b0, 32'h3F80_0000, 32'h7FA0_0000);
        chk("R4 snan b", {31'd0, op_invalid}, 32'd1);
        op_step(1'b0, 32'hFFC0_0001, 32'h7F80_0000);
        chk("R4 qnan no flag", {31'd0, op_invalid}, 32'd0);
        @(negedge clk);
        op_vld = 1'b0; op_in[0] = 32'h7F80_0001;
        @(negedge clk);
        chk("R4 no strobe", {31'd0, op_invalid}, 32'd0);
        chk("R10 strobe low", {31'd0, op_vld_q}, 32'd0);
    endtask

    task automatic t_result();
        res_step(1'b1, 1'b0, 1'b1, 32'h8001_2345);
        chk("R5 tiny flushed", res_out, 32'h0000_0000);
        chk("R10 res_vld_q", {31'd0, res_vld_q}, 32'd1);
        res_step(1'b1, 1'b0, 1'b1, 32'h8000_0000);
        chk("R6 neg zero kept", res_out, 32'h8000_0000);
        res_step(1'b1, 1'b0, 1'b1, 32'h0000_0000);
        chk("R6 pos zero kept", res_out, 32'h0000_0000);
        res_step(1'b0, 1'b0, 1'b1, 32'h0000_0042);
        chk("R7 no ftz pass", res_out, 32'h0000_0042);
        res_step(1'b1, 1'b0, 1'b0, 32'h0000_0042);
        chk("R5 not tiny pass", res_out, 32'h0000_0042);
        res_step(1'b0, 1'b1, 1'b0, 32'hFF80_1234);
        chk("R8 snan canon", res_out, 32'h7FC0_0000);
        res_step(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        chk("R8 qnan canon", res_out, 32'h7FC0_0000);
        res_step(1'b0, 1'b1, 1'b0, 32'hFF80_0000);
        chk("R8 inf kept", res_out, 32'hFF80_0000);
        res_step(1'b0, 1'b0, 1'b0, 32'hFF80_1234);
        chk("R9 snan quieted", res_out, 32'hFFC0_1234);
        res_step(1'b0, 1'b0, 1'b0, 32'h7FD0_0001);
        chk("R9 qnan kept", res_out, 32'h7FD0_0001);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_classify();
                t_ftz_ops();
                t_invalid();
                t_result();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule